// File: doc/BRIEF.md
# Prescaled Programmable Divider Pair

This block holds the two programmable dividers that feed a phase comparator in a frequency synthesizer loop. All logic runs in one clock domain. Each divided path is driven by a one-cycle enable that marks an edge of the slow clock it represents. The reference path first divides its enable by a fixed four. A programmable R counter then divides the result, so the overall reference ratio is always four times the R word. The feedback path divides its enable directly by a 16-bit N word.

Each programmable counter is a small state machine with three named states. `CNT_IDLE` is the state after reset. `CNT_TERM` is the terminal state, and the divided output is high only in this state. `CNT_RUN` is the counting state. All transitions happen only on a cycle where the counter's input step is high:
- IDLE→TERM loads the effective ratio minus one.
- TERM→RUN decrements.
- RUN→RUN decrements while the count is above zero.
- RUN→TERM reloads the effective ratio minus one once the count reaches zero.

The ratio word is sampled only on a reload. A word written mid-period therefore takes effect at the next terminal count. Words below the legal floor are raised to the floor.

Top module: `divider_pair`

## Requirements
- R1: After reset, and for as long as no enable arrives, both `fr_pulse` and `fv_pulse` stay low.
- R2: With `fb_en` high every cycle, `fv_pulse` rises once every N cycles for N words from 1056 to 65535.
- R3: An N word below 1056 divides as if it were 1056.
- R4: With `ref_en` high every cycle, `fr_pulse` rises once every 4·R cycles for R words from 5 to 2^R_W−1.
- R5: An R word below 5 divides as if it were 5.
- R6: `fv_pulse` stays high for exactly one `fb_en` spacing. `fr_pulse` stays high for exactly one prescaled spacing, which is four `ref_en` spacings.
- R7: A word changed just after a rising output edge does not alter the period in progress. That period keeps the old ratio, and the next period uses the new one.
- R8: While its enable is low, neither output changes.
- R9: Output periods scale with enable spacing. With an enable on every g-th cycle, the periods become g·N and 4·g·R cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One-cycle strobe per reference clock edge |
| fb_en | input | 1 | One-cycle strobe per feedback clock edge |
| r_word | input | R_W | Reference counter ratio (overall reference ratio is 4× this) |
| n_word | input | N_W | Feedback counter ratio |
| fr_pulse | output | 1 | Divided reference output to the phase comparator |
| fv_pulse | output | 1 | Divided feedback output to the phase comparator |

## Verification
The N word is swept through every value just above the 1056 floor, through the floor itself, through values below it, and through the full 16-bit maximum. The R word is swept through every value from 0 to 12 and one larger value. Together these separate a correct floor clamp from an off-by-one reload and from a missing clamp. Each change is made just after a rising edge, and both the following period and the one after it are measured. This shows whether a new word is taken only at the terminal count. Enables spaced two and three cycles apart show whether the counters step on the enable or on the clock. Stopping both enables shows whether the outputs hold.

// File: rtl/divpair_pkg.sv
package divpair_pkg;
    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_TERM = 2'd2
    } cnt_state_t;
endpackage

// File: rtl/quarter_prescaler.sv
module quarter_prescaler (
    input  logic clk,
    input  logic rst_n,
    input  logic in_en,
    output logic tick
);
    logic [1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= 2'd0;
        else if (in_en)
            phase <= phase + 2'd1;
    end

    always_comb tick = in_en && (phase == 2'd3);

    // every prescaled tick is followed by a cycle without one
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/ratio_counter.sv
module ratio_counter
    import divpair_pkg::*;
#(
    parameter int W   = 16,
    parameter int MIN = 1056
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    localparam logic [W-1:0] FLOOR = W'(MIN);
    localparam logic [W-1:0] ONE   = W'(1);

    cnt_state_t   state, nxt;
    logic [W-1:0] cnt;
    logic [W-1:0] eff;

    always_comb eff = (ratio < FLOOR) ? FLOOR : ratio;

    always_comb begin
        nxt = state;
        if (step) begin
            unique case (state)
                CNT_IDLE: nxt = CNT_TERM;
                CNT_RUN:  nxt = (cnt == '0) ? CNT_TERM : CNT_RUN;
                CNT_TERM: nxt = CNT_RUN;
                default:  nxt = CNT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= CNT_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step) begin
            unique case (state)
                CNT_IDLE: cnt <= eff - ONE;
                CNT_RUN:  cnt <= (cnt == '0) ? eff - ONE : cnt - ONE;
                CNT_TERM: cnt <= cnt - ONE;
                default:  cnt <= '0;
            endcase
        end
    end

    always_comb pulse = (state == CNT_TERM);

    assert_hold_without_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pulse));

    assert_term_one_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CNT_TERM && step) |=> (state == CNT_RUN));

    // a reload never holds less than the clamped floor minus one (R3, R5)
    assert_reload_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> (cnt >= FLOOR - ONE));
endmodule

// File: rtl/divider_pair.sv
module divider_pair #(
    parameter int R_W   = 14,
    parameter int N_W   = 16,
    parameter int R_MIN = 5,
    parameter int N_MIN = 1056
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_en,
    input  logic           fb_en,
    input  logic [R_W-1:0] r_word,
    input  logic [N_W-1:0] n_word,
    output logic           fr_pulse,
    output logic           fv_pulse
);
    logic pre_tick;

    quarter_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .in_en (ref_en),
        .tick  (pre_tick)
    );

    ratio_counter #(.W(R_W), .MIN(R_MIN)) u_rcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (pre_tick),
        .ratio (r_word),
        .pulse (fr_pulse)
    );

    ratio_counter #(.W(N_W), .MIN(N_MIN)) u_ncnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (fb_en),
        .ratio (n_word),
        .pulse (fv_pulse)
    );
endmodule

// File: tb/divider_pair_tb.sv
module divider_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_en, fb_en;
    logic [13:0] r_word;
    logic [15:0] n_word;
    logic        fr_pulse, fv_pulse;

    int checks = 0;
    int fails  = 0;
    int ref_gap = 0, fb_gap = 0;
    int ref_ph = 0, fb_ph = 0;
    bit timed_out = 0;

    always #5 clk = ~clk;

    divider_pair u_dut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .fb_en(fb_en),
        .r_word(r_word), .n_word(n_word), .fr_pulse(fr_pulse), .fv_pulse(fv_pulse)
    );

    always @(negedge clk) begin
        if (ref_gap == 0) begin ref_en <= 1'b0; ref_ph <= 0; end
        else begin
            ref_en <= (ref_ph == 0);
            ref_ph <= (ref_ph + 1 >= ref_gap) ? 0 : ref_ph + 1;
        end
        if (fb_gap == 0) begin fb_en <= 1'b0; fb_ph <= 0; end
        else begin
            fb_en <= (fb_ph == 0);
            fb_ph <= (fb_ph + 1 >= fb_gap) ? 0 : fb_ph + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit sig(input bit sel);
        return sel ? fr_pulse : fv_pulse;
    endfunction

    // cycles to the next rising edge; hi = contiguous high cycles at start
    task automatic next_rise(input bit sel, output int n, output int hi);
        bit prev, cur, still;
        prev = sig(sel);
        still = prev;
        hi = prev ? 1 : 0;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            cur = sig(sel);
            if (still && cur) hi++; else still = 0;
            if (!prev && cur) break;
            prev = cur;
            if (n > 140000) begin timed_out = 1; break; end
        end
    endtask

    function automatic int nclamp(input int v);
        return (v < 1056) ? 1056 : v;
    endfunction
    function automatic int rclamp(input int v);
        return (v < 5) ? 5 : v;
    endfunction

    task automatic finish_run();
        if (timed_out) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #3_000_000;
        timed_out = 1;
        finish_run();
    end

    initial begin
        int n, hi, cur_n, cur_r;
        bit ok, s_fr, s_fv;
        int nlist[9] = '{1057, 1058, 1059, 1060, 1200, 0, 1, 1055, 1056};
        int rlist[14] = '{6, 7, 8, 9, 10, 11, 12, 0, 1, 2, 3, 4, 5, 100};

        rst_n = 1'b0; n_word = 16'd1056; r_word = 14'd5;
        ok = 1;
        repeat (10) begin @(negedge clk); if (fr_pulse || fv_pulse) ok = 0; end
        rst_n = 1'b1;
        repeat (10) begin @(negedge clk); if (fr_pulse || fv_pulse) ok = 0; end
        chk(ok, "R1 outputs low in and after reset", fr_pulse | fv_pulse, 0);

        ref_gap = 1; fb_gap = 1;
        next_rise(0, n, hi);
        next_rise(0, n, hi);
        chk(n == 1056, "R2 fv period", n, 1056);
        next_rise(0, n, hi);
        chk(hi == 1, "R6 fv width", hi, 1);
        cur_n = 1056;
        foreach (nlist[i]) begin
            n_word = 16'(nlist[i]);
            next_rise(0, n, hi);
            chk(n == cur_n, "R7 fv old period kept", n, cur_n);
            cur_n = nclamp(nlist[i]);
            next_rise(0, n, hi);
            chk(n == cur_n, (nlist[i] < 1056) ? "R3 fv clamped period" : "R2 fv period", n, cur_n);
        end

        next_rise(1, n, hi);
        next_rise(1, n, hi);
        chk(n == 20, "R4 fr period", n, 20);
        next_rise(1, n, hi);
        chk(hi == 4, "R6 fr width", hi, 4);
        cur_r = 5;
        foreach (rlist[i]) begin
            r_word = 14'(rlist[i]);
            next_rise(1, n, hi);
            chk(n == 4 * cur_r, "R7 fr old period kept", n, 4 * cur_r);
            cur_r = rclamp(rlist[i]);
            next_rise(1, n, hi);
            chk(n == 4 * cur_r, (rlist[i] < 5) ? "R5 fr clamped period" : "R4 fr period", n, 4 * cur_r);
        end

        fb_gap = 2; ref_gap = 3;
        next_rise(0, n, hi); next_rise(0, n, hi);
        next_rise(0, n, hi);
        chk(n == 2 * cur_n, "R9 fv period at gap 2", n, 2 * cur_n);
        next_rise(0, n, hi);
        chk(hi == 2, "R6 fv width at gap 2", hi, 2);
        next_rise(1, n, hi); next_rise(1, n, hi);
        next_rise(1, n, hi);
        chk(n == 12 * cur_r, "R9 fr period at gap 3", n, 12 * cur_r);
        next_rise(1, n, hi);
        chk(hi == 12, "R6 fr width at gap 3", hi, 12);

        ref_gap = 0; fb_gap = 0;
        repeat (3) @(negedge clk);
        s_fr = fr_pulse; s_fv = fv_pulse; ok = 1;
        repeat (40) begin @(negedge clk); if (fr_pulse != s_fr || fv_pulse != s_fv) ok = 0; end
        chk(ok, "R8 outputs hold without enable", fv_pulse, s_fv);

        ref_gap = 1; fb_gap = 1;
        next_rise(0, n, hi); next_rise(0, n, hi);
        n_word = 16'hFFFF;
        next_rise(0, n, hi);
        chk(n == cur_n, "R7 fv old period before max", n, cur_n);
        next_rise(0, n, hi);
        chk(n == 65535, "R2 fv period at max N", n, 65535);

        finish_run();
    end
endmodule